// File: doc/BRIEF.md
# NAND Flash Page-Read Sequencer

This block runs a complete NAND flash bus sequence from a single 32-bit command word written by a host. The host first loads two address words, a destination for the page's main bytes and a destination for its spare bytes. It then writes a command word. The sequencer then does four things in turn:

- It latches an opcode onto an 8-bit flash bus.
- It sends any chosen subset of five address bytes.
- If asked, it waits for the flash ready/busy line to show a busy pulse.
- It reads the requested number of data bytes and packs them into 32-bit words for a word-write memory port.

A normal page read uses two commands. The first carries opcode 0x00 with all five address bytes and no transfer. The second carries opcode 0x30, sets the wait flag and asks for 0x840 bytes. The first 0x800 of those bytes go to the main destination and the last 0x40 go to the spare destination. A reset uses opcode 0xFF with no address and no transfer.

The register port has six word registers, selected by `regSel`:

| `regSel` | Write | Read |
|---|---|---|
| 0 | command | status |
| 1 | configuration | configuration |
| 2 | address-low | address-low |
| 3 | address-high | address-high |
| 4 | main destination | main destination |
| 5 | spare destination | spare destination |

Reads are combinational.

Top module: `nfc_seq`

## Requirements
- R1: After reset, the status word reads 0 and the flash strobes are idle: `nandWeN`=1, `nandReN`=1, `nandCle`=0, `nandAle`=0. `memWe` is 0.
- R2: A command write with bit 31 set, made while idle, starts an operation. Status bit 31 reads 1 until the operation ends. A command write with bit 31 clear starts nothing and puts no cycle on the bus.
- R3: The first latched bus cycle of every operation has `nandCle`=1 and `nandAle`=0. It carries the opcode in command bits 23:16.
- R4: Command bits 28:24 form an address mask. Address cycles (`nandAle`=1) follow the opcode from mask bit 4 down to bit 0, one per set bit. Mask bit 4 sends address-low bits 7:0. Mask bit n (n=3..0) sends address-high bits 8n+7:8n.
- R5: When command bit 15 is set, no read strobe occurs until `nandRbN` has first gone low and then returned high.
- R6: Configuration bits 15:0, when nonzero, are a timeout in cycles for the ready/busy wait. If the timeout expires, the operation ends with no data read and status bit 30 set. The next accepted command clears status bit 30.
- R7: Command bits 11:0 give the number of bytes read. Each byte takes one read strobe. A length of 0 reads nothing.
- R8: Bytes are packed little-endian into 32-bit words, with the first byte in bits 7:0. A final partial word is written with its unused upper bytes set to 0.
- R9: Bytes 0..0x7FF are written from the main destination upward, one word address step of 4 per word. Later bytes are written from the spare destination upward. Destination bits 1:0 are ignored and read back as 0.
- R10: A command write made while status bit 31 is set is ignored. It causes no bus cycles or memory writes beyond those of the running operation.
- R11: Every bus cycle is two clock cycles. On a latch cycle, `nandWeN` is low for one cycle and then high for one. On a read cycle, `nandReN` is low for one cycle and the data is sampled at the end of that low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data |
| nandIoIn | input | 8 | Flash data bus input |
| nandIoOut | output | 8 | Flash data bus output |
| nandIoOe | output | 1 | Flash data bus output enable |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandRbN | input | 1 | Ready/busy, low means busy |
| memWe | output | 1 | Memory word write strobe |
| memAddr | output | 32 | Memory byte address, word aligned |
| memWdata | output | 32 | Memory write data |

## Verification
The assertions check properties that must hold on every cycle:

- command and address latch are never both high;
- each strobe pulse lasts exactly one cycle;
- the bus is never driven while the read strobe is low;
- a memory write only happens during an operation, on an aligned address;
- an accepted command latches the opcode at once and clears the error bit.

Only the bench scenarios can show that the content is right. That covers the order and values of the address bytes under each mask, the little-endian packing of partial words, the split at the 0x800 boundary, the low-then-high busy wait, the timeout, and the dropping of commands written while busy.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD_LO, ST_CMD_HI, ST_ADR_LO, ST_ADR_HI,
    ST_WT_LO, ST_WT_HI, ST_RD_LO, ST_RD_HI
  } seqState_t;

  typedef struct packed {
    logic start;    // accepted command: latch it, clear counters and error
    logic capByte;  // sample flash data at this edge
    logic setErr;   // ready/busy wait timed out
  } seqStrobe_t;

  localparam logic [2:0] SEL_CMD   = 3'd0;
  localparam logic [2:0] SEL_CFG   = 3'd1;
  localparam logic [2:0] SEL_ADRLO = 3'd2;
  localparam logic [2:0] SEL_ADRHI = 3'd3;
  localparam logic [2:0] SEL_DTGT  = 3'd4;
  localparam logic [2:0] SEL_STGT  = 3'd5;

  localparam int START_BIT = 31;
  localparam int WAIT_BIT  = 15;
  localparam int OPC_LSB   = 16;
  localparam int MASK_LSB  = 24;
endpackage

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [31:0]      cmdWord,
  input  logic [39:0]      adrVec,
  input  logic [TMO_W-1:0] tmoLimit,
  input  logic [LEN_W-1:0] byteCnt,
  input  logic             nandRbN,
  output logic             busy,
  output seqStrobe_t       stb,
  output logic [7:0]       nandIoOut,
  output logic             nandIoOe,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN
);
  seqState_t state, stateNxt;
  logic [4:0] pendMask, pendMaskNxt;
  logic [TMO_W-1:0] tmoCnt;
  logic [2:0] curSel;
  logic [LEN_W-1:0] xferLen;
  logic tmoHit;
  seqState_t afterAdr;

  function automatic logic [2:0] topBit(input logic [4:0] m);
    logic [2:0] r;
    r = 3'd0;
    for (int i = 0; i < 5; i++) if (m[i]) r = 3'(i);
    return r;
  endfunction

  assign curSel  = topBit(pendMask);
  assign xferLen = cmdWord[LEN_W-1:0];
  assign tmoHit  = (tmoLimit != '0) && (tmoCnt == tmoLimit - 1'b1);
  assign busy    = (state != ST_IDLE);

  always_comb begin
    if (cmdWord[WAIT_BIT])    afterAdr = ST_WT_LO;
    else if (xferLen != '0)   afterAdr = ST_RD_LO;
    else                      afterAdr = ST_IDLE;
  end

  always_comb begin
    stateNxt    = state;
    pendMaskNxt = pendMask;
    stb         = '0;
    unique case (state)
      ST_IDLE: if (startReq) begin
        stb.start = 1'b1;
        stateNxt  = ST_CMD_LO;
      end
      ST_CMD_LO: stateNxt = ST_CMD_HI;
      ST_CMD_HI: begin
        pendMaskNxt = cmdWord[MASK_LSB +: 5];
        stateNxt    = (cmdWord[MASK_LSB +: 5] != '0) ? ST_ADR_LO : afterAdr;
      end
      ST_ADR_LO: stateNxt = ST_ADR_HI;
      ST_ADR_HI: begin
        pendMaskNxt         = pendMask;
        pendMaskNxt[curSel] = 1'b0;
        stateNxt            = (pendMaskNxt != '0) ? ST_ADR_LO : afterAdr;
      end
      ST_WT_LO: begin
        if (tmoHit) begin
          stb.setErr = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (!nandRbN) stateNxt = ST_WT_HI;
      end
      ST_WT_HI: begin
        if (tmoHit) begin
          stb.setErr = 1'b1;
          stateNxt   = ST_IDLE;
        end else if (nandRbN) stateNxt = (xferLen != '0) ? ST_RD_LO : ST_IDLE;
      end
      ST_RD_LO: begin
        stb.capByte = 1'b1;
        stateNxt    = ST_RD_HI;
      end
      ST_RD_HI: stateNxt = (byteCnt == xferLen) ? ST_IDLE : ST_RD_LO;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendMask <= '0;
      tmoCnt   <= '0;
    end else begin
      state    <= stateNxt;
      pendMask <= pendMaskNxt;
      if (state == ST_WT_LO || state == ST_WT_HI) tmoCnt <= tmoCnt + 1'b1;
      else                                        tmoCnt <= '0;
    end
  end

  always_comb begin
    nandCle   = (state == ST_CMD_LO) || (state == ST_CMD_HI);
    nandAle   = (state == ST_ADR_LO) || (state == ST_ADR_HI);
    nandWeN   = !((state == ST_CMD_LO) || (state == ST_ADR_LO));
    nandReN   = (state != ST_RD_LO);
    nandIoOe  = nandCle || nandAle;
    nandIoOut = nandCle ? cmdWord[OPC_LSB +: 8] :
                nandAle ? adrVec[8*curSel +: 8] : 8'h00;
  end

  // R2
  start_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> (nandCle && !nandWeN && busy));
  // R4
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));
  // R11
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |=> nandWeN);
  // R11
  re_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |=> nandReN);
  // R5
  wait_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WT_LO) |-> nandReN);
endmodule

// File: rtl/nfc_dpath.sv
module nfc_dpath
  import nfc_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int TMO_W      = 16,
  parameter int MAIN_BYTES = 2048
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [2:0]       regSel,
  input  logic [31:0]      regWdata,
  output logic [31:0]      regRdata,
  input  logic             busy,
  input  seqStrobe_t       stb,
  input  logic [7:0]       nandIoIn,
  output logic             startReq,
  output logic [31:0]      cmdWord,
  output logic [39:0]      adrVec,
  output logic [TMO_W-1:0] tmoLimit,
  output logic [LEN_W-1:0] byteCnt,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [31:0]      memWdata
);
  localparam logic [LEN_W-1:0] MAIN_LIM = LEN_W'(MAIN_BYTES);

  logic [31:0] cfgReg, adrHi, dTgt, sTgt;
  logic [15:0] adrLo;
  logic        errFlag;
  logic [31:0] packWord, packNxt, wordAddr;
  logic [1:0]  lane;
  logic        lastByte;
  logic [LEN_W-1:0] laneBase;

  assign startReq = regWe && (regSel == SEL_CMD) && regWdata[START_BIT] && !busy;
  assign adrVec   = {adrLo[7:0], adrHi};
  assign tmoLimit = cfgReg[TMO_W-1:0];

  always_comb begin
    unique case (regSel)
      SEL_CMD:   regRdata = {busy, errFlag, 30'b0};
      SEL_CFG:   regRdata = cfgReg;
      SEL_ADRLO: regRdata = {16'b0, adrLo};
      SEL_ADRHI: regRdata = adrHi;
      SEL_DTGT:  regRdata = dTgt;
      SEL_STGT:  regRdata = sTgt;
      default:   regRdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0; adrLo <= '0; adrHi <= '0; dTgt <= '0; sTgt <= '0;
      cmdWord <= '0;
    end else begin
      if (stb.start) cmdWord <= regWdata;
      if (regWe) begin
        unique case (regSel)
          SEL_CFG:   cfgReg <= regWdata;
          SEL_ADRLO: adrLo  <= regWdata[15:0];
          SEL_ADRHI: adrHi  <= regWdata;
          SEL_DTGT:  dTgt   <= {regWdata[31:2], 2'b00};
          SEL_STGT:  sTgt   <= {regWdata[31:2], 2'b00};
          default: ;
        endcase
      end
    end
  end

  assign lane     = byteCnt[1:0];
  assign lastByte = (byteCnt + 1'b1) == cmdWord[LEN_W-1:0];
  assign laneBase = {byteCnt[LEN_W-1:2], 2'b00};
  assign wordAddr = (byteCnt < MAIN_LIM) ? dTgt + 32'(laneBase)
                                         : sTgt + 32'(laneBase - MAIN_LIM);

  always_comb begin
    packNxt = (lane == 2'd0) ? 32'b0 : packWord;
    packNxt[8*lane +: 8] = nandIoIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0; byteCnt <= '0; packWord <= '0;
      memWe <= 1'b0; memAddr <= '0; memWdata <= '0;
    end else begin
      memWe <= 1'b0;
      if (stb.start) begin
        errFlag <= 1'b0;
        byteCnt <= '0;
      end else if (stb.setErr) errFlag <= 1'b1;
      if (stb.capByte) begin
        packWord <= packNxt;
        byteCnt  <= byteCnt + 1'b1;
        if (lane == 2'd3 || lastByte) begin
          memWe    <= 1'b1;
          memAddr  <= wordAddr;
          memWdata <= packNxt;
        end
      end
    end
  end

  // R9
  wr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[1:0] == 2'b00));
  // R2
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.start |=> !errFlag);
endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int TMO_W      = 16,
  parameter int MAIN_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [2:0]  regSel,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic [7:0]  nandIoIn,
  output logic [7:0]  nandIoOut,
  output logic        nandIoOe,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  input  logic        nandRbN,
  output logic        memWe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata
);
  seqStrobe_t       stb;
  logic             busy, startReq;
  logic [31:0]      cmdWord;
  logic [39:0]      adrVec;
  logic [TMO_W-1:0] tmoLimit;
  logic [LEN_W-1:0] byteCnt;

  nfc_ctrl #(.LEN_W(LEN_W), .TMO_W(TMO_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmdWord(cmdWord),
    .adrVec(adrVec), .tmoLimit(tmoLimit), .byteCnt(byteCnt),
    .nandRbN(nandRbN), .busy(busy), .stb(stb), .nandIoOut(nandIoOut),
    .nandIoOe(nandIoOe), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN));

  nfc_dpath #(.LEN_W(LEN_W), .TMO_W(TMO_W), .MAIN_BYTES(MAIN_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel),
    .regWdata(regWdata), .regRdata(regRdata), .busy(busy), .stb(stb),
    .nandIoIn(nandIoIn), .startReq(startReq), .cmdWord(cmdWord),
    .adrVec(adrVec), .tmoLimit(tmoLimit), .byteCnt(byteCnt),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata));

  // R11
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(nandIoOe && !nandReN));
endmodule

// File: tb/tb_nfc_seq.sv
module tb_nfc_seq;
  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0, nandRbN = 1'b1;
  logic [2:0] regSel = '0;
  logic [31:0] regWdata = '0, regRdata, memAddr, memWdata;
  logic [7:0] nandIoIn = '0, nandIoOut;
  logic nandIoOe, nandCle, nandAle, nandWeN, nandReN, memWe;

  nfc_seq dut (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int reCnt = 0, firstRe = -1;
  logic [7:0] patSeed = 8'h11;
  logic [9:0]  busLog [0:15];
  int busN = 0;
  logic [31:0] capA [0:599];
  logic [31:0] capD [0:599];
  int capN = 0;

  function automatic logic [7:0] patByte(input int i, input logic [7:0] s);
    return 8'(i * 29) ^ s ^ 8'(i >> 8);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge nandReN) begin
    nandIoIn = patByte(reCnt, patSeed);
    if (reCnt == 0) firstRe = cyc;
    reCnt++;
  end

  always @(negedge clk) begin
    if (!nandWeN && busN < 16) begin busLog[busN] = {nandCle, nandAle, nandIoOut}; busN++; end
    if (memWe && capN < 600) begin capA[capN] = memAddr; capD[capN] = memWdata; capN++; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%h expected=%h", req, act, exp); end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); regSel = s; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    @(negedge clk); regSel = s; #1 v = regRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    do rd(3'd0, v); while (v[31]);
  endtask

  task automatic clearLogs();
    busN = 0; capN = 0; reCnt = 0; firstRe = -1;
  endtask

  task automatic checkBus(input string req, input logic [7:0] opc, input logic [4:0] mask,
                          input logic [15:0] a0, input logic [31:0] a1);
    logic [9:0] exp [0:5];
    int n = 1;
    bit ok;
    exp[0] = {2'b10, opc};
    for (int b = 4; b >= 0; b--) if (mask[b]) begin
      exp[n] = {2'b01, (b == 4) ? a0[7:0] : a1[8*b +: 8]};
      n++;
    end
    chk(busN == n, req, busN, n);
    ok = (busN == n);
    for (int i = 0; i < n && i < busN; i++)
      if (busLog[i] != exp[i]) begin
        ok = 0;
        chk(0, req, {22'b0, busLog[i]}, {22'b0, exp[i]});
        break;
      end
    if (ok) chk(1, req, 0, 0);
  endtask

  task automatic checkWrites(input string req, input int len, input logic [31:0] dT, input logic [31:0] sT);
    int nw = 0;
    bit ok = 1;
    for (int b = 0; b < len; b += 4) begin
      logic [31:0] w = 0, a;
      for (int j = 0; j < 4; j++) if (b + j < len) w[8*j +: 8] = patByte(b + j, patSeed);
      a = (b < 2048) ? dT + b : sT + (b - 2048);
      if (ok && (nw >= capN || capA[nw] != a || capD[nw] != w)) begin
        ok = 0;
        chk(0, req, (nw < capN) ? capD[nw] : 32'hdead, w);
        chk(0, req, (nw < capN) ? capA[nw] : 32'hdead, a);
      end
      nw++;
    end
    chk(capN == nw, req, capN, nw);
    chk(reCnt == len, "R7", reCnt, len);
    if (ok) chk(1, req, 0, 0);
  endtask

  task automatic runOp(input logic [7:0] opc, input logic [4:0] mask, input int len,
                       input logic [15:0] a0, input logic [31:0] a1,
                       input logic [31:0] dT, input logic [31:0] sT);
    wr(3'd2, {16'b0, a0}); wr(3'd3, a1); wr(3'd4, dT); wr(3'd5, sT);
    clearLogs();
    wr(3'd0, {1'b1, 2'b0, mask, opc, 4'b0, 12'(len)});
    waitIdle();
    checkBus("R3 R4", opc, mask, a0, a1);
    checkWrites("R8 R9", len, dT, sT);
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(3'd0, v);
    chk(v == 0, "R1", v, 0);
    chk({nandWeN, nandReN, nandCle, nandAle, memWe} == 5'b11000, "R1",
        {nandWeN, nandReN, nandCle, nandAle, memWe}, 5'b11000);

    // R2 no start bit: nothing happens
    clearLogs();
    wr(3'd0, 32'h1F30_0010);
    repeat (6) @(negedge clk);
    rd(3'd0, v);
    chk(v[31] == 0 && busN == 0, "R2", {v[31], 31'(busN)}, 0);

    // typical two-command page read: setup then confirm with wait and full page
    runOp(8'h00, 5'h1F, 0, 16'hA1B2, 32'hC3D4E5F6, 32'h100, 32'h4000);
    // R5 busy wait low-then-high
    begin
      int riseCyc = 0, reAtRise = 0;
      bit stillBusy = 0;
      clearLogs();
      patSeed = 8'h5A;
      fork
        begin
          wr(3'd0, {1'b1, 2'b0, 5'h00, 8'h30, 4'b1000, 12'h840});
          waitIdle();
        end
        begin
          repeat (20) @(negedge clk);
          #1 stillBusy = regRdata[31];
          nandRbN = 1'b0;
          repeat (12) @(negedge clk);
          reAtRise = reCnt;
          nandRbN = 1'b1;
          riseCyc = cyc;
        end
      join
      chk(stillBusy && reAtRise == 0, "R5", reAtRise, 0);
      chk(firstRe > riseCyc, "R5", firstRe, riseCyc + 1);
      checkBus("R3", 8'h30, 5'h00, 0, 0);
      checkWrites("R9", 32'h840, 32'h100, 32'h4000);
    end

    // R6 timeout with ready/busy never going low
    wr(3'd1, 32'd40);
    clearLogs();
    wr(3'd0, {1'b1, 2'b0, 5'h00, 8'h30, 4'b1000, 12'd16});
    waitIdle();
    rd(3'd0, v);
    chk(v[30] == 1'b1, "R6", v, 32'h4000_0000);
    chk(reCnt == 0 && capN == 0, "R6", reCnt + capN, 0);
    patSeed = 8'h33;
    runOp(8'hFF, 5'h00, 0, 0, 0, 0, 0);
    rd(3'd0, v);
    chk(v[30] == 1'b0, "R6", v, 0);

    // R10 command written while busy is dropped
    clearLogs();
    wr(3'd0, {1'b1, 2'b0, 5'h00, 8'h90, 4'b0, 12'd20});
    wr(3'd0, {1'b1, 2'b0, 5'h1F, 8'h77, 4'b0, 12'd4});
    waitIdle();
    chk(busN == 1 && busLog[0][7:0] == 8'h90, "R10", busN, 1);
    chk(capN == 5 && reCnt == 20, "R10", capN, 5);

    // R7 R8 R4 random commands
    wr(3'd1, 32'd0);
    for (int k = 0; k < 10; k++) begin
      patSeed = 8'($urandom);
      runOp(8'($urandom), 5'($urandom), int'($urandom % 45),
            16'($urandom), $urandom, $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC);
    end
    // R8 single-byte partial word
    runOp(8'h00, 5'h10, 1, 16'h00EE, 32'h0, 32'h20, 32'h40);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule